// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a VLAN ID, a port membership mask, a valid flag and an optional forwarding priority. Software changes the table through two 32-bit host registers. It first writes a data word that carries the membership mask and a valid flag. It then writes a command word that carries an opcode, a VLAN ID, a port number and an optional priority, with the active bit set. The engine then scans the table, one entry per clock cycle. While the scan runs it reports busy. It clears the active bit once the last entry has been visited.

Four operations change the table:
- Clear every entry.
- Write one entry.
- Drop the entry for one VLAN ID.
- Strip one port from the mask of every entry.

When a write finds neither a matching entry nor a free one, the engine raises a sticky full flag. A combinational lookup port returns the mask and priority stored for a given VLAN ID. The switching datapath uses this port.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, no entry is valid. Busy and full are 0, and both host registers read back as zero.
- R2: A command-word write with bit 3 (active) set while idle makes busy (readback bit 3) rise on the next cycle. Busy then stays high for exactly 16 cycles. A command-word write with bit 3 clear stores its fields but launches nothing.
- R3: While busy is high, a write to the command word is ignored. The stored opcode, VLAN ID and port do not change, and no second operation runs.
- R4: Load (opcode 2) with a VLAN ID that no valid entry holds fills the lowest-index invalid entry. It takes mask and valid from the data word, where the mask is in bits 9:0 and valid is bit 11.
- R5: Load with a VLAN ID that a valid entry already holds rewrites that entry in place, including its valid flag, and uses no free entry.
- R6: Load that finds neither a match nor a free entry leaves the table unchanged and sets full (readback bit 4). Full holds after the command ends and clears when the next command launches.
- R7: Flush (opcode 1) leaves no valid entry.
- R8: Purge (opcode 3) invalidates only the valid entry whose VLAN ID equals the command's VLAN ID. A purge of an absent ID changes nothing.
- R9: Remove-port (opcode 4) clears mask bit N in every entry, where N is the command's port field (bits 11:8). Port numbers 10 to 15 change nothing.
- R10: Opcodes 0, 5, 6 and 7 run a full-length scan that leaves the table unchanged, and the table never changes while busy is low.
- R11: The command word reads back as opcode in bits 2:0, busy in bit 3, full in bit 4, port in bits 11:8, VLAN ID in bits 27:16, priority in bits 30:28 and priority-enable in bit 31. Reserved bits read as zero. The data word reads back as mask in bits 9:0 and valid in bit 11.
- R12: The lookup port reports a hit only for a VLAN ID held by a valid entry. On a hit it returns that entry's mask, and the priority and priority-enable stored by the load command that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 1 | Register select: 0 command word, 1 data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the selected register |
| busy | output | 1 | A command is running |
| full_flag | output | 1 | Sticky: the last load found no room |
| lookup_vid | input | 12 | VLAN ID to look up |
| lookup_hit | output | 1 | A valid entry holds lookup_vid |
| lookup_mask | output | 10 | Port membership of the hit entry |
| lookup_prio | output | 3 | Stored priority of the hit entry |
| lookup_prio_en | output | 1 | Stored priority-enable of the hit entry |

## Verification
The assertions check the following on every cycle:
- Launch raises busy, and busy stays high no longer than one full scan.
- Command writes made while busy leave the stored fields unchanged.
- Full rises only at the end of a load and drops at each launch.
- A finished flush leaves no valid entry.
- The table never changes while idle, and it gains at most one valid entry per cycle.

Only the bench scenarios can show the following:
- Which slot a load selects, and whether it updates an entry in place or fills a new one.
- That purge and remove-port reach exactly the intended entries and bits.
- The readback layout.
- That the lookup returns the stored mask and priority after long sequences of mixed commands.

// File: rtl/vtu_pkg.sv
package vtu_pkg;

  // Command word layout (software decodes these positions)
  localparam int OP_LSB    = 0;
  localparam int OP_W      = 3;
  localparam int ACT_BIT   = 3;
  localparam int FULL_BIT  = 4;
  localparam int PSEL_LSB  = 8;
  localparam int PSEL_W    = 4;
  localparam int VID_LSB   = 16;
  localparam int VID_W     = 12;
  localparam int PRI_LSB   = 28;
  localparam int PRI_W     = 3;
  localparam int PRIEN_BIT = 31;

  // Data word layout
  localparam int DVALID_BIT = 11;

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic [OP_W-1:0] {
    OPC_NOP    = 3'd0,
    OPC_FLUSH  = 3'd1,
    OPC_LOAD   = 3'd2,
    OPC_PURGE  = 3'd3,
    OPC_RMPORT = 3'd4
  } vtu_opc_e;

  typedef struct packed {
    logic              prio_en;
    logic [PRI_W-1:0]  prio;
    logic [VID_W-1:0]  vid;
    logic [PSEL_W-1:0] port;
    logic [OP_W-1:0]   op;
  } cmd_t;

endpackage

// File: rtl/vtu_rst_sync.sv
module vtu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vtu_host_regs.sv
module vtu_host_regs
  import vtu_pkg::*;
#(
  parameter int MASK_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              full,
  output cmd_t              cmd,
  output logic [MASK_W-1:0] dmask,
  output logic              dvalid,
  output logic              launch,
  output logic [31:0]       rdata
);
  cmd_t              cmd_q, cmd_d;
  logic [MASK_W-1:0] dmask_q, dmask_d;
  logic              dvalid_q, dvalid_d;
  logic              cmd_we, dat_we;
  logic              unused_bits;

  assign unused_bits = ^{wdata[7:4], wdata[15:12]};

  always_comb begin
    cmd_we = wr_en && (addr == ADDR_CMD) && !busy;
    dat_we = wr_en && (addr == ADDR_DATA);
    launch = cmd_we && wdata[ACT_BIT];
  end

  always_comb begin
    cmd_d    = cmd_q;
    dmask_d  = dmask_q;
    dvalid_d = dvalid_q;
    if (cmd_we) begin
      cmd_d.op      = wdata[OP_LSB +: OP_W];
      cmd_d.port    = wdata[PSEL_LSB +: PSEL_W];
      cmd_d.vid     = wdata[VID_LSB +: VID_W];
      cmd_d.prio    = wdata[PRI_LSB +: PRI_W];
      cmd_d.prio_en = wdata[PRIEN_BIT];
    end
    if (dat_we) begin
      dmask_d  = wdata[MASK_W-1:0];
      dvalid_d = wdata[DVALID_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dmask_q  <= '0;
      dvalid_q <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cmd_d;
      if (dat_we) begin
        dmask_q  <= dmask_d;
        dvalid_q <= dvalid_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CMD) begin
      rdata[OP_LSB +: OP_W]     = cmd_q.op;
      rdata[ACT_BIT]            = busy;
      rdata[FULL_BIT]           = full;
      rdata[PSEL_LSB +: PSEL_W] = cmd_q.port;
      rdata[VID_LSB +: VID_W]   = cmd_q.vid;
      rdata[PRI_LSB +: PRI_W]   = cmd_q.prio;
      rdata[PRIEN_BIT]          = cmd_q.prio_en;
    end else begin
      rdata[MASK_W-1:0]         = dmask_q;
      rdata[DVALID_BIT]         = dvalid_q;
    end
  end

  assign cmd    = cmd_q;
  assign dmask  = dmask_q;
  assign dvalid = dvalid_q;
endmodule

// File: rtl/vtu_scan_seq.sv
module vtu_scan_seq
  import vtu_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [OP_W-1:0]  op,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             scan_valid,
  input  logic [VID_W-1:0] scan_vid,
  output logic             busy,
  output logic             full,
  output logic [IDX_W-1:0] scan_idx,
  output logic             clr_valid,
  output logic             clr_port,
  output logic             load_we,
  output logic [IDX_W-1:0] load_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic             busy_q, busy_d;
  logic             full_q, full_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mfnd_q, mfnd_d, ffnd_q, ffnd_d;
  logic [IDX_W-1:0] midx_q, midx_d, fidx_q, fidx_d;
  logic             last, cur_match, cur_free, is_load, room;
  logic             seq_en;

  always_comb begin
    last      = (idx_q == LAST_IDX);
    cur_match = scan_valid && (scan_vid == cmd_vid);
    cur_free  = !scan_valid;
    is_load   = (op == OPC_LOAD);
    // running search including the entry under the scan pointer
    mfnd_d    = mfnd_q | cur_match;
    midx_d    = mfnd_q ? midx_q : idx_q;
    ffnd_d    = ffnd_q | cur_free;
    fidx_d    = ffnd_q ? fidx_q : idx_q;
    room      = mfnd_d || ffnd_d;

    clr_valid = busy_q && ((op == OPC_FLUSH) || ((op == OPC_PURGE) && cur_match));
    clr_port  = busy_q && (op == OPC_RMPORT);
    load_we   = busy_q && last && is_load && room;
    load_idx  = mfnd_d ? midx_d : fidx_d;
  end

  always_comb begin
    busy_d = busy_q;
    full_d = full_q;
    idx_d  = idx_q;
    if (launch) begin
      busy_d = 1'b1;
      full_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        if (is_load && !room) full_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  assign seq_en = launch | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      idx_q  <= '0;
      mfnd_q <= 1'b0;
      ffnd_q <= 1'b0;
      midx_q <= '0;
      fidx_q <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      full_q <= full_d;
      idx_q  <= idx_d;
      if (launch) begin
        mfnd_q <= 1'b0;
        ffnd_q <= 1'b0;
      end else begin
        mfnd_q <= mfnd_d;
        ffnd_q <= ffnd_d;
        midx_q <= midx_d;
        fidx_q <= fidx_d;
      end
    end
  end

  assign busy     = busy_q;
  assign full     = full_q;
  assign scan_idx = idx_q;
endmodule

// File: rtl/vtu_entry_table.sv
module vtu_entry_table
  import vtu_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int MASK_W      = 10,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       scan_idx,
  input  logic                   clr_valid,
  input  logic                   clr_port,
  input  logic [PSEL_W-1:0]      port_sel,
  input  logic                   load_we,
  input  logic [IDX_W-1:0]       load_idx,
  input  logic                   ld_valid,
  input  logic [VID_W-1:0]       ld_vid,
  input  logic [MASK_W-1:0]      ld_mask,
  input  logic [PRI_W-1:0]       ld_prio,
  input  logic                   ld_prio_en,
  output logic                   scan_valid,
  output logic [VID_W-1:0]       scan_vid,
  output logic [NUM_ENTRIES-1:0] valid_vec,
  input  logic [VID_W-1:0]       lookup_vid,
  output logic                   lookup_hit,
  output logic [MASK_W-1:0]      lookup_mask,
  output logic [PRI_W-1:0]       lookup_prio,
  output logic                   lookup_prio_en
);
  logic [VID_W-1:0]  vid_arr  [NUM_ENTRIES];
  logic [MASK_W-1:0] mask_arr [NUM_ENTRIES];
  logic [PRI_W-1:0]  prio_arr [NUM_ENTRIES];
  logic              pen_arr  [NUM_ENTRIES];
  logic [MASK_W-1:0] port_bit;

  // port numbers beyond the mask width decode to no bit at all
  always_comb begin
    port_bit = '0;
    for (int p = 0; p < MASK_W; p++)
      if (port_sel == PSEL_W'(p)) port_bit[p] = 1'b1;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic              v_q, v_d;
    logic [VID_W-1:0]  vid_q, vid_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic [PRI_W-1:0]  prio_q, prio_d;
    logic              pen_q, pen_d;
    logic              at_scan, at_load, ent_en;

    always_comb begin
      at_scan = (scan_idx == IDX_W'(e));
      at_load = load_we && (load_idx == IDX_W'(e));
      ent_en  = at_load || (at_scan && (clr_valid || clr_port));
      v_d    = v_q;
      vid_d  = vid_q;
      mask_d = mask_q;
      prio_d = prio_q;
      pen_d  = pen_q;
      if (at_scan && clr_valid) v_d    = 1'b0;
      if (at_scan && clr_port)  mask_d = mask_q & ~port_bit;
      if (at_load) begin
        v_d    = ld_valid;
        vid_d  = ld_vid;
        mask_d = ld_mask;
        prio_d = ld_prio;
        pen_d  = ld_prio_en;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        vid_q  <= '0;
        mask_q <= '0;
        prio_q <= '0;
        pen_q  <= 1'b0;
      end else if (ent_en) begin
        v_q    <= v_d;
        vid_q  <= vid_d;
        mask_q <= mask_d;
        prio_q <= prio_d;
        pen_q  <= pen_d;
      end
    end

    assign valid_vec[e] = v_q;
    assign vid_arr[e]   = vid_q;
    assign mask_arr[e]  = mask_q;
    assign prio_arr[e]  = prio_q;
    assign pen_arr[e]   = pen_q;
  end

  assign scan_valid = valid_vec[scan_idx];
  assign scan_vid   = vid_arr[scan_idx];

  // lowest matching index wins
  always_comb begin
    lookup_hit     = 1'b0;
    lookup_mask    = '0;
    lookup_prio    = '0;
    lookup_prio_en = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (valid_vec[i] && (vid_arr[i] == lookup_vid)) begin
        lookup_hit     = 1'b1;
        lookup_mask    = mask_arr[i];
        lookup_prio    = prio_arr[i];
        lookup_prio_en = pen_arr[i];
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vtu_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int MASK_W      = 10,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              busy,
  output logic              full_flag,
  input  logic [VID_W-1:0]  lookup_vid,
  output logic              lookup_hit,
  output logic [MASK_W-1:0] lookup_mask,
  output logic [PRI_W-1:0]  lookup_prio,
  output logic              lookup_prio_en
);
  logic                   rst_n_sync;
  cmd_t                   cmd;
  logic [OP_W-1:0]        cmd_op;
  logic [VID_W-1:0]       cmd_vid;
  logic [PSEL_W-1:0]      cmd_port;
  logic [MASK_W-1:0]      dmask;
  logic                   dvalid;
  logic                   launch;
  logic                   busy_i, full_i;
  logic [IDX_W-1:0]       scan_idx, load_idx;
  logic                   clr_valid, clr_port, load_we;
  logic                   scan_valid;
  logic [VID_W-1:0]       scan_vid;
  logic [NUM_ENTRIES-1:0] valid_vec;

  vtu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  vtu_host_regs #(.MASK_W(MASK_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_en  (host_wr),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .busy   (busy_i),
    .full   (full_i),
    .cmd    (cmd),
    .dmask  (dmask),
    .dvalid (dvalid),
    .launch (launch),
    .rdata  (host_rdata)
  );

  assign cmd_op   = cmd.op;
  assign cmd_vid  = cmd.vid;
  assign cmd_port = cmd.port;

  vtu_scan_seq #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .launch     (launch),
    .op         (cmd_op),
    .cmd_vid    (cmd_vid),
    .scan_valid (scan_valid),
    .scan_vid   (scan_vid),
    .busy       (busy_i),
    .full       (full_i),
    .scan_idx   (scan_idx),
    .clr_valid  (clr_valid),
    .clr_port   (clr_port),
    .load_we    (load_we),
    .load_idx   (load_idx)
  );

  vtu_entry_table #(.NUM_ENTRIES(NUM_ENTRIES), .MASK_W(MASK_W)) u_tbl (
    .clk            (clk),
    .rst_n          (rst_n_sync),
    .scan_idx       (scan_idx),
    .clr_valid      (clr_valid),
    .clr_port       (clr_port),
    .port_sel       (cmd_port),
    .load_we        (load_we),
    .load_idx       (load_idx),
    .ld_valid       (dvalid),
    .ld_vid         (cmd_vid),
    .ld_mask        (dmask),
    .ld_prio        (cmd.prio),
    .ld_prio_en     (cmd.prio_en),
    .scan_valid     (scan_valid),
    .scan_vid       (scan_vid),
    .valid_vec      (valid_vec),
    .lookup_vid     (lookup_vid),
    .lookup_hit     (lookup_hit),
    .lookup_mask    (lookup_mask),
    .lookup_prio    (lookup_prio),
    .lookup_prio_en (lookup_prio_en)
  );

  assign busy      = busy_i;
  assign full_flag = full_i;
endmodule

// File: rtl/vlan_cmd_engine_chk.sv
module vlan_cmd_engine_chk
  import vtu_pkg::*;
#(
  parameter int N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_addr,
  input logic [31:0]       host_wdata,
  input logic              busy,
  input logic              full,
  input logic [OP_W-1:0]   cmd_op,
  input logic [VID_W-1:0]  cmd_vid,
  input logic [PSEL_W-1:0] cmd_port,
  input logic [N-1:0]      valid_vec
);
  localparam int RUN_W = $clog2(N + 2) + 1;

  logic [RUN_W-1:0] run_q;
  logic             unused_wdata;
  logic             go;

  assign unused_wdata = ^{host_wdata[31:4], host_wdata[2:0]};
  assign go = host_wr && (host_addr == ADDR_CMD) && host_wdata[ACT_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= N);

  assert_cmd_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == ADDR_CMD) && busy)
      |=> ($stable(cmd_op) && $stable(cmd_vid) && $stable(cmd_port)));

  assert_full_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(busy) && ($past(cmd_op) == OPC_LOAD)));

  assert_full_clears_on_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !full);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && (cmd_op == OPC_FLUSH)) |-> (valid_vec == '0));

  assert_table_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(valid_vec));

  assert_one_new_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) <= $countones($past(valid_vec)) + 1);
endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .busy       (busy),
  .full       (full_flag),
  .cmd_op     (cmd_op),
  .cmd_vid    (cmd_vid),
  .cmd_port   (cmd_port),
  .valid_vec  (valid_vec)
);

// File: tb/tb_vlan_cmd_engine.sv
`timescale 1ns/1ps
module tb_vlan_cmd_engine;
  localparam int N  = 16;
  localparam int MW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic          host_addr = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          busy, full_flag;
  logic [11:0]   lookup_vid = '0;
  logic          lookup_hit;
  logic [MW-1:0] lookup_mask;
  logic [2:0]    lookup_prio;
  logic          lookup_prio_en;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [11:0]   m_vid   [N];
  logic [MW-1:0] m_mask  [N];
  logic          m_valid [N];
  logic [2:0]    m_prio  [N];
  logic          m_pen   [N];
  logic          m_full;

  always #2 clk = ~clk;

  vlan_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .full_flag(full_flag), .lookup_vid(lookup_vid), .lookup_hit(lookup_hit),
    .lookup_mask(lookup_mask), .lookup_prio(lookup_prio),
    .lookup_prio_en(lookup_prio_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cmd(input int op, input logic [11:0] vid,
      input logic [3:0] port, input logic [2:0] prio, input logic pen,
      input logic act);
    return {pen, prio, vid, 4'b0, port, 3'b0, 1'b0, act, 3'(op)};
  endfunction

  task automatic wr_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic run_cmd(input int op, input logic [11:0] vid, input logic [3:0] port,
                         input logic [2:0] prio, input logic pen);
    int cnt = 0;
    wr_reg(1'b0, pack_cmd(op, vid, port, prio, pen, 1'b1));
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R2", "busy cycles", cnt, 16);
  endtask

  function automatic int m_find(input logic [11:0] v);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vid[i] == v) return i;
    return -1;
  endfunction

  task automatic do_load(input logic [11:0] vid, input logic [MW-1:0] mask,
                         input logic vld, input logic [2:0] prio, input logic pen);
    int slot;
    wr_reg(1'b1, 32'({vld, 1'b0, mask}));
    run_cmd(2, vid, 4'd0, prio, pen);
    slot = m_find(vid);
    if (slot < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
    m_full = (slot < 0);
    if (slot >= 0) begin
      m_vid[slot] = vid; m_mask[slot] = mask; m_valid[slot] = vld;
      m_prio[slot] = prio; m_pen[slot] = pen;
    end
    chk(m_full ? "R6" : "R4", "full flag after load", 32'(full_flag), 32'(m_full));
  endtask

  task automatic check_vid(input string req, input logic [11:0] v);
    int s;
    lookup_vid = v;
    #0.5;
    s = m_find(v);
    chk(req, "lookup hit", 32'(lookup_hit), 32'(s >= 0));
    if (s >= 0) begin
      chk(req, "lookup mask", 32'(lookup_mask), 32'(m_mask[s]));
      chk("R12", "lookup prio", 32'({lookup_prio_en, lookup_prio}),
          32'({m_pen[s], m_prio[s]}));
    end
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < N; i++) check_vid(req, m_vid[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vid[i] = 12'h100 + 12'(i * 37);
      m_mask[i] = '0; m_valid[i] = 1'b0; m_prio[i] = '0; m_pen[i] = 1'b0;
    end
    m_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "full", 32'(full_flag), 0);
    host_addr = 1'b0; #0.5;
    chk("R1", "cmd readback", host_rdata, 0);
    host_addr = 1'b1; #0.5;
    chk("R1", "data readback", host_rdata, 0);
    check_table("R1");

    // R11: readback layout, reserved bits zero; R2: no launch without active bit
    wr_reg(1'b1, 32'hFFFF_FFFF);
    host_addr = 1'b1; #0.5;
    chk("R11", "data readback", host_rdata, 32'h0000_0BFF);
    wr_reg(1'b0, 32'hFFFF_FFF7);
    host_addr = 1'b0; #0.5;
    chk("R11", "cmd readback", host_rdata, 32'hFFFF_0F07);
    chk("R2", "no launch without active", 32'(busy), 0);
    check_table("R2");

    // R4/R12: fill every entry
    for (int i = 0; i < N; i++) begin
      do_load(m_vid[i], MW'((i * 93 + 5) % 1024), 1'b1, 3'(i % 8), 1'(i % 2));
      check_vid("R4", m_vid[i]);
    end
    check_table("R4");

    // R10: undefined and no-op opcodes leave the table alone
    foreach (m_vid[k]) begin
      if (k < 4) begin
        run_cmd((k == 0) ? 0 : 4 + k, m_vid[k], 4'd1, 3'd0, 1'b0);
        check_table("R10");
      end
    end

    // R6: no room for a new VID
    do_load(12'hEEE, 10'h3FF, 1'b1, 3'd1, 1'b1);
    host_addr = 1'b0; #0.5;
    chk("R6", "full readback bit", 32'(host_rdata[4]), 1);
    check_vid("R6", 12'hEEE);
    check_table("R6");

    // R5: existing VID is updated in place even when table is full
    do_load(m_vid[5], 10'h2A5, 1'b1, 3'd6, 1'b1);
    chk("R6", "full cleared on launch", 32'(full_flag), 0);
    check_table("R5");

    // R9: remove every port number, including ones beyond the mask
    for (int p = 0; p < 16; p++) begin
      run_cmd(4, 12'h000, 4'(p), 3'd0, 1'b0);
      if (p < MW) for (int i = 0; i < N; i++) m_mask[i][p] = 1'b0;
      check_table("R9");
    end

    // R8: purge one VID, then an absent one
    run_cmd(3, m_vid[3], 4'd0, 3'd0, 1'b0);
    m_valid[3] = 1'b0;
    check_table("R8");
    run_cmd(3, 12'hDDD, 4'd0, 3'd0, 1'b0);
    check_table("R8");
    // the freed slot is the only room left
    do_load(12'hABC, 10'h155, 1'b1, 3'd2, 1'b0);
    check_vid("R4", 12'hABC);
    do_load(12'hABD, 10'h0AA, 1'b1, 3'd2, 1'b0);
    chk("R6", "full when freed slot used", 32'(full_flag), 1);
    check_table("R6");

    // R3: command write while busy is ignored
    wr_reg(1'b1, 32'h0000_0801);
    wr_reg(1'b0, pack_cmd(0, 12'h111, 4'd2, 3'd0, 1'b0, 1'b1));
    wr_reg(1'b0, pack_cmd(2, 12'h222, 4'd5, 3'd3, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    host_addr = 1'b0; #0.5;
    chk("R3", "cmd readback after ignored write", host_rdata,
        pack_cmd(0, 12'h111, 4'd2, 3'd0, 1'b0, 1'b0));
    chk("R3", "busy after one scan", 32'(busy), 0);
    check_vid("R3", 12'h222);
    check_table("R3");

    // R7: flush empties the table
    run_cmd(1, 12'h000, 4'd0, 3'd0, 1'b0);
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    check_table("R7");
    check_vid("R7", 12'hABC);

    // R5: in-place update of the valid flag itself
    do_load(12'h050, 10'h00F, 1'b1, 3'd4, 1'b1);
    check_vid("R5", 12'h050);
    do_load(12'h050, 10'h00F, 1'b0, 3'd4, 1'b1);
    check_vid("R5", 12'h050);
    chk("R5", "no full on in-place", 32'(full_flag), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule